// File: doc/BRIEF.md
# Link Controller Power-Up Reset Sequencer

This block takes a serial-link controller and its PHY from full reset to a running state with timed steps. A one-cycle `start` request launches the run. Three clock-gate enables come on one per cycle: PHY clock, then bus clock, then core clock. Next the PHY power-down is lifted. After a short wait the reference clock enable is raised. A clock-settling wait follows. The block then drives a reset pulse on an external endpoint pin, releases the PHY reset, and samples a PLL-locked input a bounded number of times.

Every wait is counted in microseconds. The microsecond is made from a cycles-per-microsecond parameter. A divisor parameter shrinks every wait by the same factor, so fast builds can use short delays. At the end of a run the block reports completion on `done`. If the PLL never locked within the retry budget, it also raises `lock_timeout`. A hold input forces everything back to the reset state at any time. The clock gates, the PHY and the endpoint are outside the block; they are seen only as enables, reset lines and one status input.

Top module: `linkpwr_seq`

## Requirements
- R1: On the clock edge that accepts `start` in the idle state, `phy_clk_en` rises. `bus_clk_en` rises one cycle later and `core_clk_en` one cycle after that. The same edge clears the other enables and sets `phy_pd` and `phy_rst`.
- R2: `phy_pd` falls one cycle after `core_clk_en` rises. `ref_clk_en` rises REF*C+1 cycles after `phy_pd` falls.
- R3: When `ep_present` is 1, the endpoint pin goes to its active level SETTLE*C+1 cycles after `ref_clk_en` rises and stays there for EP*C+1 cycles. The active level is high when `ep_active_high` is 1 and low when it is 0. The start edge drives the pin to its inactive level.
- R4: `phy_rst` falls on the cycle the endpoint pin returns to inactive. When `ep_present` is 0, the pin stays inactive for the whole run and `phy_rst` falls SETTLE*C+1 cycles after `ref_clk_en` rises.
- R5: `pll_locked` is sampled first one cycle after `phy_rst` falls, then every GAP*C+2 cycles, for at most POLL_MAX samples. A lock seen on the last allowed sample counts as lock.
- R6: When a sample sees lock, `done` rises one cycle later and `lock_timeout` stays 0. When the last sample misses lock, `lock_timeout` rises at that sample and `done` rises one cycle later.
- R7: `done` and `lock_timeout` hold their values until the next accepted `start`. A `start` that arrives while a run is in progress is ignored.
- R8: Each wait X lasts max(1, X_US/DLY_DIV) microseconds. Each microsecond is CYC_PER_US clock cycles. Here C = CYC_PER_US, and REF, SETTLE, EP and GAP are the scaled values.
- R9: When `hold_rst` is 1 at an edge, the next cycle shows all clock enables 0, `phy_pd` 1, `phy_rst` 1, the endpoint pin at its active level, `done` 0, `lock_timeout` 0 and the sequencer idle. `hold_rst` takes priority over `start` in the same cycle.
- R10: After synchronous reset `rst`, the outputs take the same values as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a power-up run (accepted only when idle) |
| hold_rst | input | 1 | Force every enable off and every reset on |
| ep_present | input | 1 | 1 when an endpoint reset pin is fitted |
| ep_active_high | input | 1 | Active level of the endpoint reset pin (1 = high) |
| pll_locked | input | 1 | PHY PLL lock status |
| phy_clk_en | output | 1 | PHY clock gate enable |
| bus_clk_en | output | 1 | Bus clock gate enable |
| core_clk_en | output | 1 | Core clock gate enable |
| phy_pd | output | 1 | PHY power-down, active high |
| ref_clk_en | output | 1 | Reference clock enable |
| ep_rst_pin | output | 1 | Endpoint reset pin level |
| phy_rst | output | 1 | PHY reset, active high |
| done | output | 1 | Run finished |
| lock_timeout | output | 1 | PLL never locked within the retry budget |

## Verification
Two events can land in the same cycle, and each needs a rule for which one wins.

The first is `hold_rst` arriving together with `start`. The bench raises both in the same cycle in the middle of a run. It then checks that every output is back at its reset value and that no new run begins afterwards.

The second is a PLL lock arriving on exactly the final permitted sample, the cycle in which the timeout would otherwise be declared. One stimulus vector times `pll_locked` to appear only at sample POLL_MAX. The bench then expects `done` with `lock_timeout` still 0, at the cycle the sample spacing predicts.

// File: rtl/lpseq_pkg.sv
package lpseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_BUS,
    S_CORE,
    S_PDREL,
    S_REFW,
    S_SETTLE,
    S_EPHOLD,
    S_POLL,
    S_GAP,
    S_FIN
  } seq_state_t;

  // Scaled delay in microseconds, never below one.
  function automatic int scaled_us(input int raw_us, input int div);
    int q;
    q = (div < 1) ? raw_us : raw_us / div;
    return (q < 1) ? 1 : q;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lpseq_tick.sv
module lpseq_tick #(
  parameter int CYC_PER_US = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);

  logic [PRE_W-1:0] pre_q;

  assign tick = en && !clr && (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || !en) begin
      pre_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  generate
    if (CYC_PER_US > 1) begin : g_tick_chk
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R8
    end
  endgenerate

endmodule

// File: rtl/lpseq_delay.sv
module lpseq_delay #(
  parameter int CYC_PER_US = 100,
  parameter int US_W       = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [US_W-1:0] load_us,
  output logic            expired
);
  logic [US_W-1:0] cnt_q;
  logic            tick;

  lpseq_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (load),
    .en   (cnt_q != '0),
    .tick (tick)
  );

  assign expired = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_us;
    end else if (tick) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1)); // R8
  AST_CNT_REST: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q == '0) |=> cnt_q == '0); // R8

endmodule

// File: rtl/linkpwr_seq.sv
module linkpwr_seq
  import lpseq_pkg::*;
#(
  parameter int CYC_PER_US  = 100,
  parameter int DLY_DIV     = 1,
  parameter int REF_WAIT_US = 10,
  parameter int SETTLE_US   = 200,
  parameter int EP_PULSE_US = 100000,
  parameter int POLL_GAP_US = 50,
  parameter int POLL_MAX    = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic hold_rst,
  input  logic ep_present,
  input  logic ep_active_high,
  input  logic pll_locked,
  output logic phy_clk_en,
  output logic bus_clk_en,
  output logic core_clk_en,
  output logic phy_pd,
  output logic ref_clk_en,
  output logic ep_rst_pin,
  output logic phy_rst,
  output logic done,
  output logic lock_timeout
);
  localparam int REF_EFF    = scaled_us(REF_WAIT_US, DLY_DIV);
  localparam int SETTLE_EFF = scaled_us(SETTLE_US, DLY_DIV);
  localparam int EP_EFF     = scaled_us(EP_PULSE_US, DLY_DIV);
  localparam int GAP_EFF    = scaled_us(POLL_GAP_US, DLY_DIV);
  localparam int MAX_US     = max_of(max_of(REF_EFF, SETTLE_EFF), max_of(EP_EFF, GAP_EFF));
  localparam int US_W       = $clog2(MAX_US + 1);
  localparam int TRY_W      = $clog2(POLL_MAX + 1);
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(POLL_MAX);

  seq_state_t       state_q;
  logic [TRY_W-1:0] tries_q;
  logic             tmr_load;
  logic [US_W-1:0]  tmr_us;
  logic             tmr_idle;
  logic             last_try;

  lpseq_delay #(.CYC_PER_US(CYC_PER_US), .US_W(US_W)) u_delay (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_us (tmr_us),
    .expired (tmr_idle)
  );

  assign last_try = (tries_q + 1'b1) == TRY_LAST;

  // Timer loads follow the state transitions below.
  always_comb begin
    tmr_load = 1'b0;
    tmr_us   = '0;
    unique case (state_q)
      S_PDREL: begin
        tmr_load = 1'b1;
        tmr_us   = US_W'(REF_EFF);
      end
      S_REFW: if (tmr_idle) begin
        tmr_load = 1'b1;
        tmr_us   = US_W'(SETTLE_EFF);
      end
      S_SETTLE: if (tmr_idle && ep_present) begin
        tmr_load = 1'b1;
        tmr_us   = US_W'(EP_EFF);
      end
      S_POLL: if (!pll_locked && !last_try) begin
        tmr_load = 1'b1;
        tmr_us   = US_W'(GAP_EFF);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || hold_rst) begin
      state_q      <= S_IDLE;
      tries_q      <= '0;
      phy_clk_en   <= 1'b0;
      bus_clk_en   <= 1'b0;
      core_clk_en  <= 1'b0;
      phy_pd       <= 1'b1;
      ref_clk_en   <= 1'b0;
      ep_rst_pin   <= ep_active_high;
      phy_rst      <= 1'b1;
      done         <= 1'b0;
      lock_timeout <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          phy_clk_en   <= 1'b1;
          bus_clk_en   <= 1'b0;
          core_clk_en  <= 1'b0;
          phy_pd       <= 1'b1;
          ref_clk_en   <= 1'b0;
          ep_rst_pin   <= !ep_active_high;
          phy_rst      <= 1'b1;
          done         <= 1'b0;
          lock_timeout <= 1'b0;
          tries_q      <= '0;
          state_q      <= S_BUS;
        end
        S_BUS: begin
          bus_clk_en <= 1'b1;
          state_q    <= S_CORE;
        end
        S_CORE: begin
          core_clk_en <= 1'b1;
          state_q     <= S_PDREL;
        end
        S_PDREL: begin
          phy_pd  <= 1'b0;
          state_q <= S_REFW;
        end
        S_REFW: if (tmr_idle) begin
          ref_clk_en <= 1'b1;
          state_q    <= S_SETTLE;
        end
        S_SETTLE: if (tmr_idle) begin
          if (ep_present) begin
            ep_rst_pin <= ep_active_high;
            state_q    <= S_EPHOLD;
          end else begin
            phy_rst <= 1'b0;
            tries_q <= '0;
            state_q <= S_POLL;
          end
        end
        S_EPHOLD: if (tmr_idle) begin
          ep_rst_pin <= !ep_active_high;
          phy_rst    <= 1'b0;
          tries_q    <= '0;
          state_q    <= S_POLL;
        end
        S_POLL: begin
          tries_q <= tries_q + 1'b1;
          if (pll_locked) begin
            state_q <= S_FIN;
          end else if (last_try) begin
            lock_timeout <= 1'b1;
            state_q      <= S_FIN;
          end else begin
            state_q <= S_GAP;
          end
        end
        S_GAP: if (tmr_idle) begin
          state_q <= S_POLL;
        end
        S_FIN: begin
          done    <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_BUS_AFTER_PHY: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_clk_en) |-> phy_clk_en); // R1
  AST_CORE_AFTER_BUS: assert property (@(posedge clk) disable iff (rst)
    $rose(core_clk_en) |-> (bus_clk_en && phy_clk_en)); // R1
  AST_REF_AFTER_PD: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_clk_en) |-> (core_clk_en && !phy_pd)); // R2
  AST_PHYRST_LATE: assert property (@(posedge clk) disable iff (rst)
    $fell(phy_rst) |-> (ref_clk_en && ep_rst_pin != ep_active_high)); // R4
  AST_TIMEOUT_BUDGET: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_timeout) |-> tries_q == TRY_LAST); // R5
  AST_DONE_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_timeout) |=> $rose(done)); // R6
  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    hold_rst |=> (!phy_clk_en && !bus_clk_en && !core_clk_en && !ref_clk_en
                  && phy_pd && phy_rst && !done && !lock_timeout)); // R9

endmodule

// File: tb/linkpwr_seq_bench.sv
module linkpwr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int C   = 2;
  localparam int DIV = 100;
  localparam int M   = 2000;
  localparam int REF = (10 / DIV < 1) ? 1 : 10 / DIV;
  localparam int SET = (200 / DIV < 1) ? 1 : 200 / DIV;
  localparam int EPW = (100000 / DIV < 1) ? 1 : 100000 / DIV;
  localparam int GAP = (50 / DIV < 1) ? 1 : 50 / DIV;
  localparam int P   = GAP * C + 2;
  localparam int WDOG = 150000;
  localparam int NVEC = 5;
  // {ep_present, ep_active_high, lock on sample k (0 = never), extra start offset}
  localparam int VEC [NVEC][4] = '{
    '{1, 1, 1, 0},
    '{1, 0, 3, 0},
    '{0, 1, 2, 10},
    '{0, 0, 0, 0},
    '{1, 1, M, 0}
  };

  logic clk = 1'b0;
  logic rst, start, hold_rst, ep_present, ep_active_high, pll_locked;
  logic phy_clk_en, bus_clk_en, core_clk_en, phy_pd, ref_clk_en;
  logic ep_rst_pin, phy_rst, done, lock_timeout;
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  linkpwr_seq #(
    .CYC_PER_US(C), .DLY_DIV(DIV), .REF_WAIT_US(10), .SETTLE_US(200),
    .EP_PULSE_US(100000), .POLL_GAP_US(50), .POLL_MAX(M)
  ) u_linkpwr_seq (
    .clk(clk), .rst(rst), .start(start), .hold_rst(hold_rst),
    .ep_present(ep_present), .ep_active_high(ep_active_high),
    .pll_locked(pll_locked), .phy_clk_en(phy_clk_en), .bus_clk_en(bus_clk_en),
    .core_clk_en(core_clk_en), .phy_pd(phy_pd), .ref_clk_en(ref_clk_en),
    .ep_rst_pin(ep_rst_pin), .phy_rst(phy_rst), .done(done),
    .lock_timeout(lock_timeout)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, WDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_reset_state(input string tag, input bit ahi);
    check(!phy_clk_en && !bus_clk_en && !core_clk_en && !ref_clk_en, {tag, " enables off"},
          {phy_clk_en, bus_clk_en, core_clk_en, ref_clk_en}, 0);
    check(phy_pd && phy_rst, {tag, " pd/rst on"}, {phy_pd, phy_rst}, 3);
    check(ep_rst_pin == ahi, {tag, " pin active"}, ep_rst_pin, ahi);
    check(!done && !lock_timeout, {tag, " flags clear"}, {done, lock_timeout}, 0);
  endtask

  task automatic run_vec(input bit pres, input bit ahi, input int k, input int xs);
    int t_phy = -1, t_bus = -1, t_core = -1, t_pd = -1, t_ref = -1;
    int t_on = -1, t_off = -1, t_rst = -1, t_to = -1, t_done = -1;
    bit pin_bad = 0;
    int e_ref, e_rst, e_done, e_to;
    ep_present = pres; ep_active_high = ahi; pll_locked = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    t_phy = cyc;
    check(phy_clk_en && !bus_clk_en, "R1 phy first", {phy_clk_en, bus_clk_en}, 2);
    check(ep_rst_pin != ahi, "R3 pin inactive at start", ep_rst_pin, !ahi);
    for (int i = 0; i < 30000 && t_done < 0; i++) begin
      @(negedge clk);
      if (t_bus < 0 && bus_clk_en) t_bus = cyc;
      if (t_core < 0 && core_clk_en) t_core = cyc;
      if (t_pd < 0 && !phy_pd) t_pd = cyc;
      if (t_ref < 0 && ref_clk_en) t_ref = cyc;
      if (t_ref >= 0 && t_on < 0 && ep_rst_pin == ahi) t_on = cyc;
      if (t_on >= 0 && t_off < 0 && ep_rst_pin != ahi) t_off = cyc;
      if (!pres && ep_rst_pin == ahi) pin_bad = 1;
      if (t_rst < 0 && !phy_rst) t_rst = cyc;
      if (t_to < 0 && lock_timeout) t_to = cyc;
      if (done) t_done = cyc;
      if (t_rst >= 0 && k > 0 && cyc == t_rst + (k - 1) * P) pll_locked = 1'b1;
      start = (xs > 0 && cyc == t_phy + xs);
    end
    start = 1'b0;
    check(t_bus == t_phy + 1, "R1 bus clock", t_bus - t_phy, 1);
    check(t_core == t_phy + 2, "R1 core clock", t_core - t_phy, 2);
    check(t_pd == t_phy + 3, "R2 power-down release", t_pd - t_phy, 3);
    e_ref = t_pd + REF * C + 1;
    check(t_ref == e_ref, "R2 R8 ref clock wait", t_ref - t_pd, REF * C + 1);
    if (pres) begin
      check(t_on == t_ref + SET * C + 1, "R3 settle before pulse", t_on - t_ref, SET * C + 1);
      check(t_off == t_on + EPW * C + 1, "R3 pulse width", t_off - t_on, EPW * C + 1);
      e_rst = t_off;
      check(t_rst == e_rst, "R4 phy reset with pin release", t_rst, e_rst);
    end else begin
      e_rst = e_ref + SET * C + 1;
      check(t_rst == e_rst, "R4 phy reset without pin", t_rst, e_rst);
      check(!pin_bad, "R4 pin stays inactive", pin_bad, 0);
    end
    if (k > 0) begin
      e_done = e_rst + 1 + (k - 1) * P + 1;
      check(t_done == e_done, "R5 R6 done after lock", t_done, e_done);
      check(t_to < 0 && !lock_timeout, "R6 no timeout on lock", lock_timeout, 0);
    end else begin
      e_to = e_rst + 1 + (M - 1) * P;
      check(t_to == e_to, "R5 timeout at last sample", t_to, e_to);
      check(t_done == e_to + 1, "R6 done after timeout", t_done, e_to + 1);
    end
    pll_locked = 1'b0;
    repeat (5) @(negedge clk);
    check(done && lock_timeout == (k == 0), "R7 flags held", {done, lock_timeout}, {1'b1, k == 0});
    if (xs > 0) check(t_done >= 0, "R7 start while busy ignored", t_done, e_done);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; hold_rst = 1'b0;
    ep_present = 1'b1; ep_active_high = 1'b1; pll_locked = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset_state("R10 after reset", 1'b1);

    for (int v = 0; v < NVEC; v++) begin
      run_vec(VEC[v][0] != 0, VEC[v][1] != 0, VEC[v][2], VEC[v][3]);
    end

    // Hold and start in the same cycle, mid-run: hold wins.
    ep_present = 1'b1; ep_active_high = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (8) @(negedge clk);
    check(ref_clk_en, "R9 run in progress before hold", ref_clk_en, 1);
    hold_rst = 1'b1; start = 1'b1;
    @(negedge clk); hold_rst = 1'b0; start = 1'b0;
    check_reset_state("R9 hold", 1'b0);
    repeat (4) @(negedge clk);
    check(!phy_clk_en && !bus_clk_en, "R9 hold beat start", phy_clk_en, 0);

    // Clean run after the hold still works.
    run_vec(1'b0, 1'b1, 1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule